// File: doc/BRIEF.md
# SPI Master with Byte FIFOs

This block is a memory-mapped SPI master that moves 8-bit words. Software reaches it over a simple register bus (write strobe, read strobe, byte address, 16-bit data). It sees a control register, a status register, a transmit data port, a receive data port and a slave-select register. A transmit FIFO and a receive FIFO sit between the bus and the shift engine. The engine drives SCK, MOSI and a bank of active-low selects. For every byte it sends out, it collects one byte from MISO.

The usual flow is in four steps. Software sets the transmit hold bit and preloads up to a FIFO's worth of bytes. It picks a slave by writing a one-hot-low pattern to the select register. It then clears the hold bit, and the engine drains the FIFO byte after byte. Received bytes are read back from the receive port. The SCK half-period is a build-time parameter. Clock polarity and phase are set by software. An external select input that goes low while the master is enabled raises a sticky fault. The fault stops new transfers until a soft reset.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the status register reads 0x05. The select register reads all ones, every select output is high and SCK sits at level 0.
- R2: The bus decodes these byte addresses. Control is at 0x62 and is 16 bits wide; its stored bits read back. Status is at 0x67. Transmit data is at 0x6b (write). Receive data is at 0x6f (read). Select is at 0x70. Soft reset is at 0x40. The control bits are: 0x02 enable, 0x04 master, 0x08 CPOL, 0x10 CPHA, 0x20 transmit flush, 0x40 receive flush, 0x80 manual select and 0x100 transmit hold.
- R3: While the hold bit is set, no SCK edge occurs, even with bytes in the transmit FIFO.
- R4: With enable and master set and hold clear, the engine sends the queued bytes in write order, MSB first. Each byte takes 16 SCK edges.
- R5: Each byte shifted out captures one MISO byte, MSB first. That byte is pushed into the receive FIFO, and the receive port returns the captured bytes in order.
- R6: SCK idles at the CPOL level. With CPHA=0, data is sampled on the leading edge of each bit; with CPHA=1, it is sampled on the trailing edge.
- R7: Status bit 3 means transmit full and bit 2 means transmit empty. A write to a full 16-entry transmit FIFO is dropped.
- R8: Status bit 0 means receive empty and bit 1 means receive full. A read of an empty receive FIFO returns 0 and pops nothing. A byte that arrives while the receive FIFO is full is discarded.
- R9: The two flush bits empty their FIFO in the cycle of the write. They always read back as 0.
- R10: In manual mode the select outputs equal the select register. In automatic mode they equal it only while a byte is shifting and are all high otherwise.
- R11: Writing exactly 0x000a to address 0x40 returns all registers, FIFOs and the engine to the reset state. Any other value there has no effect.
- R12: If the fault input is low while enable and master are set, status bit 4 sets and stays set. While it is set, no new byte starts.
- R13: Consecutive SCK edges inside a byte are exactly HALF_DIV clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (pops the receive FIFO at 0x6f) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle bus_re is high |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | NSS | Active-low slave selects |
| spi_fault_n | input | 1 | External select; low while enabled raises a fault |

## Verification
The bench plays the slave in all four clock modes and rebuilds each byte from the sampled MOSI bits. A design that samples on the wrong edge, or sends LSB first, produces scrambled bytes. A design that ignores the hold bit produces edges that nobody expects. The FIFO boundaries are driven hard. A seventeenth write must vanish rather than overwrite the head, and a seventeenth received byte must be dropped. An empty read must yield zero rather than stale data or a pointer slip. The bench also checks select behaviour, flush self-clearing, the soft-reset key and fault blocking, all from the pins and registers. A design that drops the select between bits in manual mode, or that resets on any write to 0x40, is caught there.

// File: rtl/spi_fifo_master_pkg.sv
package spi_fifo_master_pkg;
  localparam logic [7:0] OFS_SRST = 8'h40;
  localparam logic [7:0] OFS_CTRL = 8'h62;
  localparam logic [7:0] OFS_STAT = 8'h67;
  localparam logic [7:0] OFS_TXD  = 8'h6b;
  localparam logic [7:0] OFS_RXD  = 8'h6f;
  localparam logic [7:0] OFS_SEL  = 8'h70;
  localparam logic [15:0] SRST_KEY = 16'h000a;

  // bit position of each control field
  localparam int C_EN = 1, C_MST = 2, C_CPOL = 3, C_CPHA = 4;
  localparam int C_TXF = 5, C_RXF = 6, C_MAN = 7, C_HOLD = 8;

  // even edges lead, odd edges trail; CPHA picks which one samples
  function automatic logic is_sample_edge(input logic [3:0] edge_idx, input logic cpha);
    return edge_idx[0] == cpha;
  endfunction

  function automatic logic [15:0] pack_status(input logic fault, input logic txf,
      input logic txe, input logic rxf, input logic rxe);
    return {11'd0, fault, txf, txe, rxf, rxe};
  endfunction
endpackage

// File: rtl/spi_fifo_master_fifo.sv
module spi_fifo_master_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      if (do_push && !do_pop) cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/spi_fifo_master_shifter.sv
module spi_fifo_master_shifter
  import spi_fifo_master_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       cpol,
  input  logic       cpha,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sck,
  output logic       mosi
);
  localparam int TW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [TW-1:0] tmr;
  logic [3:0] edge_n;
  logic lvl;
  logic [7:0] sh;

  wire tick = busy && (tmr == TW'(HALF_DIV - 1));
  wire smp  = is_sample_edge(edge_n, cpha);

  assign sck = cpol ^ lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; tmr <= '0; edge_n <= '0; lvl <= 1'b0;
      sh <= '0; rx_byte <= '0; mosi <= 1'b0;
    end else if (srst) begin
      busy <= 1'b0; done <= 1'b0; tmr <= '0; edge_n <= '0; lvl <= 1'b0;
      sh <= '0; rx_byte <= '0; mosi <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1; tmr <= '0; edge_n <= '0; lvl <= 1'b0;
        if (!cpha) begin
          mosi <= tx_byte[7];
          sh   <= {tx_byte[6:0], 1'b0};
        end else begin
          sh <= tx_byte;
        end
      end else if (busy) begin
        if (tick) begin
          tmr    <= '0;
          lvl    <= ~lvl;
          edge_n <= edge_n + 4'd1;
          if (smp) rx_byte <= {rx_byte[6:0], miso};
          else begin
            mosi <= sh[7];
            sh   <= {sh[6:0], 1'b0};
          end
          if (edge_n == 4'd15) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          tmr <= tmr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_master_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int HALF_DIV = 2,
  parameter int NSS      = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic           bus_re,
  input  logic [7:0]     bus_addr,
  input  logic [15:0]    bus_wdata,
  output logic [15:0]    bus_rdata,
  output logic           spi_sck,
  output logic           spi_mosi,
  input  logic           spi_miso,
  output logic [NSS-1:0] spi_ss_n,
  input  logic           spi_fault_n
);
  logic ctl_en, ctl_mst, ctl_cpol, ctl_cpha, ctl_man, ctl_hold;
  logic [NSS-1:0] sel_reg;
  logic fault;

  // named bus events
  wire wr_ctl   = bus_we && (bus_addr == OFS_CTRL);
  wire wr_tx    = bus_we && (bus_addr == OFS_TXD);
  wire wr_sel   = bus_we && (bus_addr == OFS_SEL);
  wire rd_rx    = bus_re && (bus_addr == OFS_RXD);
  wire soft_rst = bus_we && (bus_addr == OFS_SRST) && (bus_wdata == SRST_KEY);
  wire tx_flush = soft_rst || (wr_ctl && bus_wdata[C_TXF]);
  wire rx_flush = soft_rst || (wr_ctl && bus_wdata[C_RXF]);

  logic [7:0] tx_head, rx_head, rx_byte;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic busy, done, start;

  assign start = ctl_en && ctl_mst && !ctl_hold && !fault && !tx_empty && !busy;

  spi_fifo_master_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(wr_tx), .wdata(bus_wdata[7:0]),
    .pop(start), .head(tx_head), .full(tx_full), .empty(tx_empty));

  spi_fifo_master_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(done), .wdata(rx_byte),
    .pop(rd_rx), .head(rx_head), .full(rx_full), .empty(rx_empty));

  spi_fifo_master_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .srst(soft_rst), .start(start), .tx_byte(tx_head),
    .cpol(ctl_cpol), .cpha(ctl_cpha), .miso(spi_miso), .busy(busy), .done(done),
    .rx_byte(rx_byte), .sck(spi_sck), .mosi(spi_mosi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ctl_en, ctl_mst, ctl_cpol, ctl_cpha, ctl_man, ctl_hold} <= '0;
      sel_reg <= '1;
      fault   <= 1'b0;
    end else if (soft_rst) begin
      {ctl_en, ctl_mst, ctl_cpol, ctl_cpha, ctl_man, ctl_hold} <= '0;
      sel_reg <= '1;
      fault   <= 1'b0;
    end else begin
      if (wr_ctl) begin
        ctl_en   <= bus_wdata[C_EN];
        ctl_mst  <= bus_wdata[C_MST];
        ctl_cpol <= bus_wdata[C_CPOL];
        ctl_cpha <= bus_wdata[C_CPHA];
        ctl_man  <= bus_wdata[C_MAN];
        ctl_hold <= bus_wdata[C_HOLD];
      end
      if (wr_sel) sel_reg <= bus_wdata[NSS-1:0];
      if (ctl_en && ctl_mst && !spi_fault_n) fault <= 1'b1;
    end
  end

  assign spi_ss_n = (ctl_man || busy) ? sel_reg : '1;

  logic [15:0] ctl_view;
  always_comb begin
    ctl_view = '0;
    ctl_view[C_EN]   = ctl_en;
    ctl_view[C_MST]  = ctl_mst;
    ctl_view[C_CPOL] = ctl_cpol;
    ctl_view[C_CPHA] = ctl_cpha;
    ctl_view[C_MAN]  = ctl_man;
    ctl_view[C_HOLD] = ctl_hold;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (bus_addr)
        OFS_CTRL: bus_rdata = ctl_view;
        OFS_STAT: bus_rdata = pack_status(fault, tx_full, tx_empty, rx_full, rx_empty);
        OFS_RXD:  bus_rdata = rx_empty ? 16'd0 : {8'd0, rx_head};
        OFS_SEL:  bus_rdata = 16'(sel_reg);
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int NSS = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           start,
  input logic           sck,
  input logic           cpol,
  input logic           hold,
  input logic           man,
  input logic [NSS-1:0] ss_n,
  input logic [NSS-1:0] sel_reg,
  input logic           tx_full,
  input logic           tx_wr,
  input logic           tx_flush,
  input logic           rx_empty,
  input logic           rx_rd,
  input logic [15:0]    rdata,
  input logic           fault,
  input logic           srst
);
  p_idle_sck_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cpol);
  p_hold_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !start);
  p_manual_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    man |-> ss_n == sel_reg);
  p_auto_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!man && !busy) |-> &ss_n);
  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_wr && !start && !tx_flush) |=> tx_full);
  p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && rx_rd) |-> rdata == 16'd0);
  p_fault_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !start);
  p_fault_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !srst) |=> fault);
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.NSS(NSS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start(start), .sck(spi_sck), .cpol(ctl_cpol),
  .hold(ctl_hold), .man(ctl_man), .ss_n(spi_ss_n), .sel_reg(sel_reg), .tx_full(tx_full),
  .tx_wr(wr_tx), .tx_flush(tx_flush), .rx_empty(rx_empty), .rx_rd(rd_rx),
  .rdata(bus_rdata), .fault(fault), .srst(soft_rst));

// File: tb/spi_fifo_master_bench.sv
`timescale 1ns/1ps
module spi_fifo_master_bench;
  localparam int HALF = 2;
  localparam int NSS  = 8;

  logic clk = 0, rst_n = 0;
  logic bus_we = 0, bus_re = 0;
  logic [7:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic sck, mosi, miso = 0, fault_n = 1;
  logic [NSS-1:0] ss_n;

  always #2 clk = ~clk;

  spi_fifo_master #(.DEPTH(16), .HALF_DIV(HALF), .NSS(NSS)) u_spi_fifo_master (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_ss_n(ss_n), .spi_fault_n(fault_n));

  int checks = 0, errors = 0;
  bit finished = 0;
  bit hold_mon = 1;
  bit cur_cpol = 0, cur_cpha = 0;
  logic [NSS-1:0] exp_ss = '1;
  logic [7:0] exp_q[$], slave_q[$], rx_exp[$];
  logic [15:0] ctl_cur;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); bus_re = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_re = 0;
  endtask

  // driver: queue expected MOSI byte and the slave's reply
  task automatic send(input logic [7:0] tx, input logic [7:0] sl, input bit expect_it);
    if (expect_it) begin exp_q.push_back(tx); slave_q.push_back(sl); end
    bwrite(8'h6b, {8'h00, tx});
  endtask

  task automatic cfg(input bit cpol, input bit cpha, input bit man);
    hold_mon = 1;
    ctl_cur = 16'h0006 | (16'(cpol) << 3) | (16'(cpha) << 4) | (16'(man) << 7);
    bwrite(8'h62, ctl_cur | 16'h0100);
    cur_cpol = cpol; cur_cpha = cpha;
    repeat (2) @(negedge clk);
    hold_mon = 0;
  endtask

  task automatic go();
    bwrite(8'h62, ctl_cur);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic read_rx(input int n);
    logic [15:0] d;
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = rx_exp.pop_front();
      bread(8'h6f, d);
      chk(d == {8'h00, e}, "R5 rx byte", d, e);
    end
  endtask

  // monitor: rebuilds MOSI bytes, drives MISO, times edges
  logic prev_sck = 0;
  int edge_i = 0, sbit = 0, cyc = 0;
  logic [7:0] mbits = 0;
  always @(negedge clk) begin
    if (!rst_n || hold_mon) begin
      prev_sck = sck; edge_i = 0; sbit = 0; cyc = 0;
    end else begin
      cyc++;
      if (sck !== prev_sck) begin
        prev_sck = sck;
        if (edge_i == 0 && exp_q.size() == 0) chk(0, "R3 unexpected SCK edge", 1, 0);
        if (edge_i != 0) chk(cyc == HALF, "R13 edge spacing", cyc, HALF);
        if (edge_i != 15) chk(ss_n == exp_ss, "R10 select during byte", ss_n, exp_ss);
        cyc = 0;
        if ((edge_i % 2) == int'(cur_cpha)) begin
          mbits = {mbits[6:0], mosi}; sbit++;
        end
        if (edge_i == 15) begin
          logic [7:0] e;
          e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'h00;
          chk(mbits == e, (cur_cpol || cur_cpha) ? "R6 mosi byte" : "R4 mosi byte", mbits, e);
          if (slave_q.size() != 0) rx_exp.push_back(slave_q.pop_front());
          edge_i = 0; sbit = 0;
        end else edge_i++;
      end
    end
    miso = (slave_q.size() != 0 && sbit < 8) ? slave_q[0][7 - sbit] : 1'b0;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    bread(8'h67, d); chk(d == 16'h0005, "R1 status at reset", d, 16'h5);
    bread(8'h70, d); chk(d == 16'h00ff, "R1 select reg at reset", d, 16'hff);
    chk(ss_n == '1 && sck == 0, "R1 idle outputs", {ss_n, sck}, 9'h1fe);
    bread(8'h62, d); chk(d == 16'h0000, "R2 control at reset", d, 0);

    // R2 / R3: configure mode 0, hold, preload
    bwrite(8'h70, 16'h00fe); exp_ss = 8'hfe;
    cfg(0, 0, 0);
    bread(8'h62, d); chk(d == 16'h0106, "R2 control readback", d, 16'h106);
    send(8'h3c, 8'hc3, 1); send(8'h81, 8'h0f, 1); send(8'h5a, 8'hf0, 1);
    repeat (100) @(negedge clk);
    chk(sck == 0 && ss_n == '1, "R3 held idle", {ss_n, sck}, 9'h1fe);
    bread(8'h67, d); chk(d[2] == 0, "R3 tx holds data", d, 16'h1);
    chk(exp_q.size() == 3, "R3 nothing sent", exp_q.size(), 3);
    chk(ss_n == '1, "R10 auto select idle", ss_n, 8'hff);
    go(); drain();
    read_rx(3);

    // R6 the other three modes
    for (int m = 1; m < 4; m++) begin
      cfg(m[1], m[0], 0);
      chk(sck == m[1], "R6 idle level", sck, m[1]);
      send(8'(8'h96 + m), 8'(8'h21 * m), 1);
      send(8'(8'h0f ^ (m << 4)), 8'(8'hd4 - m), 1);
      go(); drain();
      read_rx(2);
    end

    // R10 manual select
    bwrite(8'h70, 16'h00fb); exp_ss = 8'hfb;
    cfg(0, 0, 1);
    chk(ss_n == 8'hfb, "R10 manual select idle", ss_n, 8'hfb);
    send(8'he7, 8'h18, 1); send(8'h42, 8'hbd, 1);
    go(); drain();
    chk(ss_n == 8'hfb, "R10 manual select after burst", ss_n, 8'hfb);
    read_rx(2);

    // R7 transmit full, R8 receive full / empty
    cfg(0, 0, 0);
    for (int i = 0; i < 17; i++) send(8'(i * 13 + 1), 8'(i * 7 + 3), i < 16);
    bread(8'h67, d); chk((d & 16'h000c) == 16'h0008, "R7 tx full status", d, 16'h8);
    go(); drain();
    bread(8'h67, d); chk((d & 16'h0003) == 16'h0002, "R8 rx full status", d, 16'h2);
    read_rx(16);
    bread(8'h6f, d); chk(d == 0, "R8 empty read gives zero", d, 0);
    bread(8'h67, d); chk(d[0] == 1, "R8 rx empty after reads", d, 1);

    // R8 overrun: seventeenth arrival dropped
    cfg(0, 1, 0);
    for (int i = 0; i < 16; i++) send(8'(i ^ 8'h55), 8'(i + 8'h80), 1);
    go();
    while (exp_q.size() > 15) @(negedge clk);
    send(8'haa, 8'h77, 1);
    drain();
    read_rx(16);
    bread(8'h6f, d); chk(d == 0, "R8 extra byte discarded", d, 0);
    void'(rx_exp.pop_front());

    // R9 flushes
    cfg(0, 0, 0);
    send(8'h11, 8'h22, 1); send(8'h33, 8'h44, 1);
    go(); drain();
    bwrite(8'h62, ctl_cur | 16'h0140);
    bread(8'h67, d); chk(d[0] == 1, "R9 rx flushed", d, 1);
    rx_exp.delete();
    cfg(0, 0, 0);
    for (int i = 0; i < 4; i++) send(8'(i), 8'h00, 0);
    bwrite(8'h62, ctl_cur | 16'h0120);
    bread(8'h67, d); chk(d[2] == 1, "R9 tx flushed", d, 1);
    bread(8'h62, d); chk(d == (ctl_cur | 16'h0100), "R9 flush bits read 0", d, ctl_cur | 16'h100);

    // R12 fault
    @(negedge clk); fault_n = 0; @(negedge clk); @(negedge clk); fault_n = 1;
    bread(8'h67, d); chk(d[4] == 1, "R12 fault flag", d, 16'h10);
    send(8'h99, 8'h00, 0);
    go();
    repeat (80) @(negedge clk);
    bread(8'h67, d); chk(d == 16'h0011, "R12 no start while faulted", d, 16'h11);

    // R11 soft reset
    bwrite(8'h40, 16'h0005);
    bread(8'h67, d); chk(d == 16'h0011, "R11 wrong key ignored", d, 16'h11);
    hold_mon = 1;
    bwrite(8'h40, 16'h000a);
    bread(8'h67, d); chk(d == 16'h0005, "R11 status cleared", d, 16'h5);
    bread(8'h62, d); chk(d == 16'h0000, "R11 control cleared", d, 0);
    bread(8'h70, d); chk(d == 16'h00ff, "R11 select cleared", d, 16'hff);
    chk(exp_q.size() == 0 && rx_exp.size() == 0, "R4 scoreboard empty", exp_q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule